// File: doc/BRIEF.md
# Ethernet Test Frame Burst Generator

This block produces a counted burst of Ethernet test frames on a 64-bit streaming source interface. The interface carries valid, ready, start-of-packet, end-of-packet and an empty-lane count. Configuration arrives on plain input pins that the surrounding register logic drives. Once transmit is enabled, the block launches frames until it has sent the programmed number. It then stays idle until a soft reset re-arms it. The checksum, MAC/PCS and register decode belong to neighbouring blocks.

Every frame opens with the destination MAC, then the source MAC, then a 16-bit length field holding the frame's byte count. A counting payload fills the rest of the frame. Frame length is either a fixed programmed size or a size that climbs by a programmed step per frame and wraps when it would pass a ceiling. Between frames the block inserts idle cycles. The count is either programmed or drawn from a pseudo-random sequence.

Top module: `pkt_burst_gen`

## Requirements
- R1: A new frame starts only in a cycle where `tx_en` is 1. With `tx_en` at 0, `out_valid` never rises.
- R2: `len_mode` 2'b01 selects fixed length and 2'b10 selects stepping length. With 2'b00 or 2'b11 no frame starts.
- R3: In fixed mode every frame carries exactly `len_size` bytes, provided that value is 64 or more.
- R4: In stepping mode the first frame's raw length equals `len_size`, and each later raw length adds `len_size`. If that sum would exceed `len_ceiling`, the raw length returns to `len_size`.
- R5: A raw length below 64 is sent as a 64-byte frame.
- R6: Frame byte p travels in beat p/8 on lanes `out_data[63-8*(p%8) -: 8]`. Bytes 0..5 hold `dst_mac` and bytes 6..11 hold `src_mac`, each most significant byte first. Bytes 12..13 hold the frame length as a big-endian 16-bit value.
- R7: Frame byte p, for p of 14 or more, equals (p-14) mod 256.
- R8: `out_sop` marks the first beat and `out_eop` the last. On the last beat `out_empty` gives the number of unused lanes, (8 - length mod 8) mod 8. On every other beat it is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values into the next cycle.
- R10: With `gap_fixed` at 1, exactly `gap_cycles` cycles with `out_valid` low separate an accepted end-of-packet from the next frame. A value of 0 sends frames back to back.
- R11: With `gap_fixed` at 0, the gap is the low 8 bits of a 16-bit shift-left LFSR with feedback b15^b13^b12^b10. The LFSR is seeded to 0xACE1 on either reset and steps once per accepted end-of-packet, after its value has been used.
- R12: One burst sends exactly `pkt_count` frames and then stops. A count of 0 sends nothing.
- R13: One cycle after `soft_rst`, `out_valid` is 0. The next burst starts again from frame zero with its first length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous generator reset; configuration inputs are unaffected |
| tx_en | input | 1 | Permits new frames to start |
| len_mode | input | 2 | Length mode code (01 fixed, 10 stepping) |
| len_size | input | 14 | Fixed size, or step size in stepping mode |
| len_ceiling | input | 14 | Upper raw length in stepping mode |
| gap_fixed | input | 1 | 1: programmed gap, 0: pseudo-random gap |
| gap_cycles | input | 8 | Programmed idle cycles between frames |
| pkt_count | input | 32 | Frames per burst |
| dst_mac | input | 48 | Destination address placed first |
| src_mac | input | 48 | Source address placed second |
| out_ready | input | 1 | Sink accepts the current beat |
| out_valid | output | 1 | Beat is present |
| out_sop | output | 1 | First beat of a frame |
| out_eop | output | 1 | Last beat of a frame |
| out_empty | output | 3 | Unused lanes in the last beat |
| out_data | output | 64 | Frame bytes, first byte in the top lane |

## Verification
The bench builds the block with its default parameters: a 64-bit path, 14-bit lengths, an 8-bit gap and a 64-byte floor. It sweeps fixed sizes 0 and 60 through 72. That range covers the 64-byte floor and every residue of length mod 8, so each empty-lane value and header-to-payload lane split is seen. Stepping runs reach the wrap at the ceiling and the floor. Back-pressure patterns exercise holding on stalled beats. Zero, programmed and pseudo-random gaps are measured cycle by cycle, and a burst aborted by a soft reset is restarted.

// File: rtl/pktgen_pkg.sv
// Shared types and helpers for the test frame burst generator.
// Assumes frames are laid out big-endian: first byte in the top lane.
package pktgen_pkg;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_SEND = 2'd1,
        GS_GAP  = 2'd2
    } gen_state_e;

    localparam logic [1:0] LM_FIXED = 2'b01;
    localparam logic [1:0] LM_STEP  = 2'b10;
    localparam int unsigned HDR_BYTES = 14;

    // Byte value at frame position p: header fields, then counting payload.
    function automatic logic [7:0] frame_byte(
        input logic [31:0]  p,
        input logic [95:0]  macs,
        input logic [15:0]  flen
    );
        logic [111:0] hdr;
        logic [111:0] sh;
        logic [31:0]  q;
        hdr = {macs, flen};
        sh  = '0;
        q   = p - HDR_BYTES;
        if (p < HDR_BYTES) begin
            sh = hdr >> (8 * (HDR_BYTES - 1 - p));
            return sh[7:0];
        end
        return q[7:0];
    endfunction

endpackage

// File: rtl/pkt_len_step.sv
// Frame length source. Fixed mode returns the size input; stepping mode
// walks size, 2*size, ... and restarts at size past the ceiling.
// Assumes 'advance' pulses once per launched frame; output is floored.
module pkt_len_step #(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             step_mode,
    input  logic [LEN_W-1:0] size,
    input  logic [LEN_W-1:0] ceiling,
    input  logic             advance,
    output logic [LEN_W-1:0] len_o
);
    logic [LEN_W:0] acc;
    logic [LEN_W:0] cur;
    logic [LEN_W:0] nxt;
    logic [LEN_W:0] raw;

    // Current and next raw lengths; acc==0 means first frame of the burst.
    always_comb begin
        cur   = (acc == '0) ? {1'b0, size} : acc;
        nxt   = cur + {1'b0, size};
        raw   = step_mode ? cur : {1'b0, size};
        len_o = (raw < (LEN_W+1)'(MIN_LEN)) ? LEN_W'(MIN_LEN) : raw[LEN_W-1:0];
    end

    // Stepping accumulator, advanced on each launch.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            acc <= '0;
        end else if (advance && step_mode) begin
            acc <= (nxt > {1'b0, ceiling}) ? {1'b0, size} : nxt;
        end
    end
endmodule

// File: rtl/pkt_gap_src.sv
// Pseudo-random gap source: 16-bit Fibonacci LFSR, shift left,
// feedback b15^b13^b12^b10. Assumes 'step' pulses once per frame end.
module pkt_gap_src #(
    parameter int          GAP_W = 8,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             step,
    output logic [GAP_W-1:0] rand_o
);
    logic [15:0] lfsr;

    assign rand_o = lfsr[GAP_W-1:0];

    // LFSR register, reseeded by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            lfsr <= SEED;
        end else if (step) begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    end
endmodule

// File: rtl/pkt_beat_fmt.sv
// Combinational beat formatter: maps beat index and frame length to the
// bytes of that beat. Assumes first byte of a beat in the top lane.
module pkt_beat_fmt
    import pktgen_pkg::*;
#(
    parameter int BYTES  = 8,
    parameter int LEN_W  = 14,
    parameter int BEAT_W = 12
) (
    input  logic [BEAT_W-1:0]  beat,
    input  logic [LEN_W-1:0]   flen,
    input  logic [47:0]        dst,
    input  logic [47:0]        src,
    output logic [8*BYTES-1:0] data
);
    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        logic [31:0] pos;
        // Frame position of this lane, then its byte value.
        always_comb begin
            pos = 32'(beat) * BYTES + j;
            data[8*(BYTES-1-j) +: 8] = frame_byte(pos, {dst, src}, 16'(flen));
        end
    end
endmodule

// File: rtl/pkt_burst_gen.sv
// Test frame burst generator top. Sequences frames of the selected
// length, inserts fixed or pseudo-random gaps and stops after the
// programmed count. Assumes configuration is steady during a burst.
module pkt_burst_gen
    import pktgen_pkg::*;
#(
    parameter int          DATA_W    = 64,
    parameter int          EMPTY_W   = $clog2(DATA_W/8),
    parameter int          LEN_W     = 14,
    parameter int          GAP_W     = 8,
    parameter int          CNT_W     = 32,
    parameter int          MIN_LEN   = 64,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               tx_en,
    input  logic [1:0]         len_mode,
    input  logic [LEN_W-1:0]   len_size,
    input  logic [LEN_W-1:0]   len_ceiling,
    input  logic               gap_fixed,
    input  logic [GAP_W-1:0]   gap_cycles,
    input  logic [CNT_W-1:0]   pkt_count,
    input  logic [47:0]        dst_mac,
    input  logic [47:0]        src_mac,
    input  logic               out_ready,
    output logic               out_valid,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic [DATA_W-1:0]  out_data
);
    localparam int BYTES  = DATA_W / 8;
    localparam int BEAT_W = LEN_W - EMPTY_W + 1;

    gen_state_e       state;
    logic [BEAT_W-1:0] beat;
    logic [LEN_W-1:0] frame_len;
    logic [CNT_W-1:0] sent;
    logic [GAP_W-1:0] gap_cnt;

    logic              mode_ok, accept, last, frame_end;
    logic              go_now, go_after, launch;
    logic [CNT_W-1:0]  sent_inc;
    logic [LEN_W-1:0]  len_now;
    logic [GAP_W-1:0]  rand_gap, gap_val;
    logic [BEAT_W-1:0] last_beat;

    // Launch decisions and handshake terms.
    always_comb begin
        mode_ok   = (len_mode == LM_FIXED) || (len_mode == LM_STEP);
        last_beat = BEAT_W'((frame_len - 1'b1) >> EMPTY_W);
        last      = (beat == last_beat);
        accept    = out_valid && out_ready;
        frame_end = accept && last;
        sent_inc  = sent + 1'b1;
        gap_val   = gap_fixed ? gap_cycles : rand_gap;
        go_now    = tx_en && mode_ok && (sent < pkt_count);
        go_after  = tx_en && mode_ok && (sent_inc < pkt_count);
        launch    = ((state == GS_IDLE) && go_now)
                 || ((state == GS_GAP) && (gap_cnt == GAP_W'(1)) && go_now)
                 || ((state == GS_SEND) && frame_end && (gap_val == '0) && go_after);
    end

    pkt_len_step #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .step_mode(len_mode == LM_STEP),
        .size     (len_size),
        .ceiling  (len_ceiling),
        .advance  (launch),
        .len_o    (len_now)
    );

    pkt_gap_src #(.GAP_W(GAP_W), .SEED(LFSR_SEED)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .step    (frame_end),
        .rand_o  (rand_gap)
    );

    pkt_beat_fmt #(.BYTES(BYTES), .LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_fmt (
        .beat(beat),
        .flen(frame_len),
        .dst (dst_mac),
        .src (src_mac),
        .data(out_data)
    );

    // Burst sequencer: idle, sending beats, or counting gap cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state     <= GS_IDLE;
            beat      <= '0;
            frame_len <= '0;
            sent      <= '0;
            gap_cnt   <= '0;
        end else begin
            if (launch) begin
                state     <= GS_SEND;
                beat      <= '0;
                frame_len <= len_now;
            end
            case (state)
                GS_SEND: begin
                    if (accept && !last) begin
                        beat <= beat + 1'b1;
                    end else if (frame_end) begin
                        sent <= sent_inc;
                        if (!launch) begin
                            if ((gap_val != '0) && go_after) begin
                                state   <= GS_GAP;
                                gap_cnt <= gap_val;
                            end else begin
                                state <= GS_IDLE;
                            end
                        end
                    end
                end
                GS_GAP: begin
                    gap_cnt <= gap_cnt - 1'b1;
                    if ((gap_cnt == GAP_W'(1)) && !launch) begin
                        state <= GS_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Stream framing outputs, all derived from held state.
    always_comb begin
        out_valid = (state == GS_SEND);
        out_sop   = out_valid && (beat == '0);
        out_eop   = out_valid && last;
        out_empty = out_eop ? EMPTY_W'(BYTES - int'(frame_len[EMPTY_W-1:0])) : '0;
    end
endmodule

// File: rtl/pkt_burst_gen_chk.sv
// Protocol checker for pkt_burst_gen, attached by bind below.
// Observes ports only, plus a frame counter of its own.
module pkt_burst_gen_chk #(
    parameter int DATA_W  = 64,
    parameter int EMPTY_W = 3,
    parameter int CNT_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_rst,
    input logic               tx_en,
    input logic [1:0]         len_mode,
    input logic [CNT_W-1:0]   pkt_count,
    input logic               out_ready,
    input logic               out_valid,
    input logic               out_sop,
    input logic               out_eop,
    input logic [EMPTY_W-1:0] out_empty,
    input logic [DATA_W-1:0]  out_data
);
    logic [CNT_W-1:0] done_cnt;

    // Frames accepted since the last reset of either kind.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) done_cnt <= '0;
        else if (out_valid && out_ready && out_eop) done_cnt <= done_cnt + 1'b1;
    end

    // R1
    tx_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(tx_en));

    // R2
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ($past(len_mode) == 2'b01 || $past(len_mode) == 2'b10));

    // R8
    empty_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eop) |-> (out_empty == '0));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                       && $stable(out_eop) && $stable(out_empty)));

    // R12
    burst_count_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (out_valid && out_ready && out_eop) |-> (done_cnt < pkt_count));

    // R13
    soft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> !out_valid);
endmodule

bind pkt_burst_gen pkt_burst_gen_chk #(
    .DATA_W (DATA_W),
    .EMPTY_W(EMPTY_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .tx_en    (tx_en),
    .len_mode (len_mode),
    .pkt_count(pkt_count),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_empty(out_empty),
    .out_data (out_data)
);

// File: tb/test_pkt_burst_gen.sv
`timescale 1ns/1ps
module test_pkt_burst_gen;
    localparam logic [47:0] DST = 48'h123456780ADD;
    localparam logic [47:0] SRC = 48'h876543210ADD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        tx_en = 1'b0;
    logic [1:0]  len_mode = 2'b01;
    logic [13:0] len_size = 14'd64;
    logic [13:0] len_ceiling = 14'h2580;
    logic        gap_fixed = 1'b1;
    logic [7:0]  gap_cycles = 8'd0;
    logic [31:0] pkt_count = 32'd10;
    logic        out_ready = 1'b1;
    logic        out_valid, out_sop, out_eop;
    logic [2:0]  out_empty;
    logic [63:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pkt_burst_gen i_pkt_burst_gen (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en),
        .len_mode(len_mode), .len_size(len_size), .len_ceiling(len_ceiling),
        .gap_fixed(gap_fixed), .gap_cycles(gap_cycles), .pkt_count(pkt_count),
        .dst_mac(DST), .src_mac(SRC), .out_ready(out_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_empty(out_empty), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Expected byte from R6/R7.
    function automatic logic [7:0] exp_byte(input int p, input int flen);
        logic [111:0] hdr;
        hdr = {DST, SRC, 16'(flen)};
        if (p < 14) return hdr[8*(13-p) +: 8];
        return 8'((p - 14) % 256);
    endfunction

    // Watch for any valid beat over n cycles.
    task automatic quiet(input int n, input string tag, input string what);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        chk(seen == 0, tag, what, seen, 0);
    endtask

    // Run one burst and check every frame against the arithmetic model.
    task automatic run_burst(input logic [1:0] mode, input int size, input int ceil_v,
                             input bit gfix, input int gcyc, input int cnt,
                             input int rdy_mod, input bit do_soft, input string ltag);
        int acc = 0, cur, raw, exp_l, exp_gap = 0, frames = 0, bytepos = 0;
        int gap_run = 0, bad = 0, hold_bad = 0, sop_bad = 0;
        bit in_frame = 0, stalled = 0;
        logic [63:0] prev = '0;
        logic [15:0] lf = 16'hACE1;
        @(negedge clk);
        len_mode = mode; len_size = 14'(size); len_ceiling = 14'(ceil_v);
        gap_fixed = gfix; gap_cycles = 8'(gcyc); pkt_count = 32'(cnt);
        if (do_soft) begin
            tx_en = 0; soft_rst = 1;
            @(negedge clk);
            soft_rst = 0;
        end
        tx_en = 1;
        // first expected length (R4/R5)
        cur = (acc == 0) ? size : acc;
        raw = (mode == 2'b10) ? cur : size;
        exp_l = (raw < 64) ? 64 : raw;
        if (mode == 2'b10) acc = (cur + size > ceil_v) ? size : cur + size;
        for (int cyc = 0; cyc < 40000 && frames < cnt; cyc++) begin
            @(negedge clk);
            out_ready = (rdy_mod == 0) ? 1'b1 : ((cyc % rdy_mod) != 0);
            if (out_valid) begin
                if (!in_frame) begin
                    in_frame = 1;
                    if (frames > 0)
                        chk(gap_run == exp_gap, gfix ? "R10" : "R11", "idle cycles", gap_run, exp_gap);
                end
                if ((bytepos == 0) != out_sop) sop_bad++;
                if (stalled && out_data != prev) hold_bad++;
                for (int j = 0; j < 8; j++)
                    if (bytepos + j < exp_l && out_data[63-8*j -: 8] != exp_byte(bytepos + j, exp_l)) bad++;
                stalled = !out_ready;
                prev = out_data;
                if (out_ready) begin
                    if (out_eop) begin
                        chk(bytepos + 8 - ((out_empty == 0) ? 8 : int'(out_empty)) + ((out_empty == 0) ? 8 : 0) - 8 + 8 == exp_l,
                            ltag, "frame bytes from eop/empty (R8)",
                            bytepos + 8 - int'(out_empty), exp_l);
                        chk(bad == 0 && sop_bad == 0, "R6/R7", "byte or sop mismatches", bad + sop_bad, 0);
                        if (rdy_mod != 0) chk(hold_bad == 0, "R9", "stall changes", hold_bad, 0);
                        bad = 0; sop_bad = 0; hold_bad = 0;
                        frames++; in_frame = 0; gap_run = 0; bytepos = 0;
                        exp_gap = gfix ? gcyc : int'(lf[7:0]);
                        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                        cur = (acc == 0) ? size : acc;
                        raw = (mode == 2'b10) ? cur : size;
                        exp_l = (raw < 64) ? 64 : raw;
                        if (mode == 2'b10) acc = (cur + size > ceil_v) ? size : cur + size;
                    end else begin
                        bytepos += 8;
                    end
                end
            end else if (frames > 0) begin
                gap_run++;
            end
        end
        out_ready = 1;
        chk(frames == cnt, "R12", "frames in burst", frames, cnt);
        quiet(40, "R12", "beats after burst end");
        tx_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!out_valid, "R13", "valid after reset", out_valid, 0);

        // R1: disabled transmit starts nothing
        len_mode = 2'b01; pkt_count = 3; tx_en = 0;
        quiet(30, "R1", "beats with tx_en low");

        // R2: reserved length codes start nothing
        tx_en = 1; len_mode = 2'b00;
        quiet(30, "R2", "beats with mode 00");
        len_mode = 2'b11;
        quiet(30, "R2", "beats with mode 11");
        tx_en = 0;

        // R3/R5/R8: fixed sizes across the floor and every residue
        run_burst(2'b01, 0, 0, 1, 3, 2, 0, 1, "R5");
        for (int s = 60; s <= 72; s++)
            run_burst(2'b01, s, 0, 1, 3, 2, 0, 1, (s < 64) ? "R5" : "R3");

        // R9/R10: back to back with back-pressure
        run_burst(2'b01, 100, 0, 1, 0, 3, 3, 1, "R3");

        // R4/R5: stepping with wrap below and above the floor
        run_burst(2'b10, 20, 130, 1, 2, 8, 0, 1, "R4");
        run_burst(2'b10, 300, 1000, 1, 1, 5, 4, 1, "R4");

        // R11: pseudo-random gaps
        run_burst(2'b01, 64, 0, 0, 0, 5, 0, 1, "R3");

        // R12: zero count sends nothing
        @(negedge clk);
        pkt_count = 0; len_mode = 2'b01; soft_rst = 1;
        @(negedge clk);
        soft_rst = 0; tx_en = 1;
        quiet(40, "R12", "beats with zero count");
        tx_en = 0;

        // R13: abort mid-frame then restart from the first length
        @(negedge clk);
        len_mode = 2'b10; len_size = 14'd90; len_ceiling = 14'd400;
        gap_fixed = 1; gap_cycles = 8'd1; pkt_count = 4; soft_rst = 1;
        @(negedge clk);
        soft_rst = 0; tx_en = 1;
        begin
            int beats = 0;
            for (int i = 0; i < 200 && beats < 17; i++) begin
                @(negedge clk);
                if (out_valid) beats++;
            end
        end
        soft_rst = 1; tx_en = 0;
        @(negedge clk);
        soft_rst = 0;
        chk(!out_valid, "R13", "valid after soft reset", out_valid, 0);
        run_burst(2'b10, 90, 400, 1, 1, 4, 0, 0, "R13");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule